// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Primitive Command Master

This block drives a serial EEPROM over a two-pin bus: a clock pin that the block always drives, and an open-drain data pin. Software does not hand the block a whole transaction. It issues one bus primitive at a time by writing a 4-bit command code. The primitives are: a start condition, a stop condition, sending a byte and checking the acknowledge, receiving a byte and acknowledging it, and receiving a final byte without acknowledging it. Any code outside that set causes no bus activity and only sets an error flag.

The block has one 8-bit data register. Software loads it before a send, and a receive overwrites it with the byte taken from the bus. The status outputs show whether the bus is active, whether the last code was illegal, whether the slave acknowledged the last sent byte, and whether the block acknowledged the last received byte. A one-cycle interrupt pulse marks the end of each primitive. Bytes go out and come in most significant bit first. Each bit lasts four quarter-periods of `QTR_CYCLES` system clocks. The default value gives about 500 kHz from a 50 MHz clock.

Top module: `twc_eeprom_master`

## Requirements
- R1: After reset, `cmd_out` is 4'b0000, `data_out` is 0, `busy`, `err`, `rx_ack`, `tx_ack` and `irq` are 0, `scl` is 1 and `sda_oe` is 0 (data released).
- R2: Code 4'b1001 produces a start condition: the data line falls while `scl` is high, and `scl` ends low.
- R3: Code 4'b0101 produces a stop condition: the data line is low while `scl` rises, then rises while `scl` is high, and `scl` stays high afterwards.
- R4: Code 4'b0011 shifts out the data register MSB first in eight clocks, releases the data line for a ninth clock, and sets `rx_ack` to 1 exactly when the line was low at that ninth clock. Outside start and stop, the data line changes only while `scl` is low.
- R5: Code 4'b0010 samples eight bits MSB first into the data register, drives the line low during the ninth clock, and sets `tx_ack` to 1.
- R6: Code 4'b0110 samples eight bits MSB first into the data register, leaves the line released during the ninth clock, and leaves `tx_ack` at 0.
- R7: Code 4'b0000 causes no bus activity, never raises `busy`, and sets `err` to 0.
- R8: Every code other than 0000, 0010, 0011, 0101, 0110 and 1001 causes no bus activity and no `busy`, and sets `err` to 1 on the cycle after the write.
- R9: Every accepted command write clears `err`, `rx_ack` and `tx_ack` before the new command starts.
- R10: `busy` is 1 from the cycle after a bus-active command write until that primitive completes. `irq` is a one-cycle pulse in the first cycle `busy` is 0 again.
- R11: Command and data writes made while `busy` is 1 are ignored: `cmd_out` and `data_out` keep their values.
- R12: During a byte, every `scl` high phase lasts exactly 2*`QTR_CYCLES` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle strobe that writes `cmd_in` |
| cmd_in | input | 4 | Primitive command code |
| data_wr | input | 1 | One-cycle strobe that writes `data_in` to the data register |
| data_in | input | 8 | Byte to send |
| cmd_out | output | 4 | Last accepted command code |
| data_out | output | 8 | Data register (byte to send or byte received) |
| busy | output | 1 | A primitive is running on the bus |
| err | output | 1 | The last command code was illegal |
| rx_ack | output | 1 | The slave acknowledged the last sent byte |
| tx_ack | output | 1 | The block acknowledged the last received byte |
| irq | output | 1 | One-cycle pulse when `busy` falls |
| scl | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_in | input | 1 | Level sensed on the data line |

## Verification
The hardest condition to reach is a write that arrives while a byte is still shifting. The stimulus pokes a new command and a new data byte into a send, two cycles after it starts. After the interrupt, the bench checks that the command code and the data register kept their values. A reactive slave model in the bench drives the shared line. It pulls the line low for the acknowledge or for received data bits, always while the clock is low. A bus monitor decodes starts, stops, bytes and acknowledge levels, and compares each against a queue that each command task fills.

// File: rtl/twc_pkg.sv
package twc_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_START,
    OP_STOP,
    OP_TX,
    OP_RX_ACK,
    OP_RX_NACK
  } twc_op_e;

  localparam logic [3:0] CODE_NOP   = 4'b0000;
  localparam logic [3:0] CODE_RXA   = 4'b0010;
  localparam logic [3:0] CODE_TX    = 4'b0011;
  localparam logic [3:0] CODE_STOP  = 4'b0101;
  localparam logic [3:0] CODE_RXN   = 4'b0110;
  localparam logic [3:0] CODE_START = 4'b1001;

  localparam int unsigned BYTE_BITS = 8;

  // Pin levels {scl, drive_low} for one quarter of a bit slot.
  function automatic logic [1:0] slot_wave(twc_op_e op, logic [1:0] ph,
                                           logic ack_slot, logic bitv);
    logic s;
    logic o;
    s = (ph == 2'd1) || (ph == 2'd2);
    o = 1'b0;
    case (op)
      OP_START:   o = ph[1];
      OP_STOP: begin
        s = (ph != 2'd0);
        o = !ph[1];
      end
      OP_TX:      o = ack_slot ? 1'b0 : !bitv;
      OP_RX_ACK:  o = ack_slot;
      OP_RX_NACK: o = 1'b0;
      default: begin
        s = 1'b1;
        o = 1'b0;
      end
    endcase
    return {s, o};
  endfunction

endpackage

// File: rtl/twc_rst_sync.sv
module twc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/twc_tick.sv
module twc_tick #(
  parameter int unsigned QTR_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (QTR_CYCLES < 2) ? 1 : $clog2(QTR_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                cnt_d = '0;
    else if (cnt_q == LAST)  cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/twc_decode.sv
module twc_decode
  import twc_pkg::*;
(
  input  logic [3:0] code,
  output twc_op_e    op,
  output logic       legal
);
  always_comb begin
    legal = 1'b1;
    op    = OP_NONE;
    case (code)
      CODE_NOP:   op = OP_NONE;
      CODE_RXA:   op = OP_RX_ACK;
      CODE_TX:    op = OP_TX;
      CODE_STOP:  op = OP_STOP;
      CODE_RXN:   op = OP_RX_NACK;
      CODE_START: op = OP_START;
      default:    legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/twc_engine.sv
module twc_engine
  import twc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 go,
  input  twc_op_e              op,
  input  logic [BYTE_BITS-1:0] tx_byte,
  input  logic                 sda_in,
  output logic                 run,
  output logic                 done,
  output logic [BYTE_BITS-1:0] rx_byte,
  output logic                 ack_seen,
  output logic                 scl,
  output logic                 sda_oe
);
  localparam int unsigned SW = $clog2(BYTE_BITS + 1);
  localparam logic [SW-1:0] ACK_SLOT = SW'(BYTE_BITS);

  logic                 active_q, active_d;
  twc_op_e              op_q, op_d;
  logic [SW-1:0]        slot_q, slot_d;
  logic [1:0]           ph_q, ph_d;
  logic [BYTE_BITS-1:0] sh_q, sh_d;
  logic                 smp_q, smp_d;
  logic                 ack_q, ack_d;
  logic                 scl_q, scl_d;
  logic                 oe_q, oe_d;
  logic                 is_byte;
  logic [SW-1:0]        last_slot;

  assign is_byte   = (op_q == OP_TX) || (op_q == OP_RX_ACK) || (op_q == OP_RX_NACK);
  assign last_slot = is_byte ? ACK_SLOT : '0;

  always_comb begin
    active_d = active_q;
    op_d     = op_q;
    slot_d   = slot_q;
    ph_d     = ph_q;
    sh_d     = sh_q;
    smp_d    = smp_q;
    ack_d    = ack_q;
    scl_d    = scl_q;
    oe_d     = oe_q;
    done     = 1'b0;
    if (go) begin
      active_d       = 1'b1;
      op_d           = op;
      slot_d         = '0;
      ph_d           = 2'd0;
      sh_d           = tx_byte;
      ack_d          = 1'b0;
      {scl_d, oe_d}  = slot_wave(op, 2'd0, 1'b0, tx_byte[BYTE_BITS-1]);
    end else if (active_q && tick) begin
      if (ph_q == 2'd2) begin
        smp_d = sda_in;
        if ((slot_q == ACK_SLOT) && (op_q == OP_TX)) ack_d = !sda_in;
      end
      if (ph_q == 2'd3) begin
        if (is_byte && (slot_q < ACK_SLOT)) sh_d = {sh_q[BYTE_BITS-2:0], smp_q};
        if (slot_q == last_slot) begin
          active_d = 1'b0;
          done     = 1'b1;
        end else begin
          slot_d        = slot_q + 1'b1;
          ph_d          = 2'd0;
          {scl_d, oe_d} = slot_wave(op_q, 2'd0, slot_d == ACK_SLOT, sh_d[BYTE_BITS-1]);
        end
      end else begin
        ph_d          = ph_q + 2'd1;
        {scl_d, oe_d} = slot_wave(op_q, ph_d, slot_q == ACK_SLOT, sh_q[BYTE_BITS-1]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      op_q     <= OP_NONE;
      slot_q   <= '0;
      ph_q     <= 2'd0;
      sh_q     <= '0;
      smp_q    <= 1'b0;
      ack_q    <= 1'b0;
      scl_q    <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      op_q     <= op_d;
      slot_q   <= slot_d;
      ph_q     <= ph_d;
      sh_q     <= sh_d;
      smp_q    <= smp_d;
      ack_q    <= ack_d;
      scl_q    <= scl_d;
      oe_q     <= oe_d;
    end
  end

  assign run      = active_q;
  assign rx_byte  = sh_d;
  assign ack_seen = ack_q;
  assign scl      = scl_q;
  assign sda_oe   = oe_q;
endmodule

// File: rtl/twc_eeprom_master.sv
module twc_eeprom_master
  import twc_pkg::*;
#(
  parameter int unsigned QTR_CYCLES = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_in,
  input  logic       data_wr,
  input  logic [7:0] data_in,
  output logic [3:0] cmd_out,
  output logic [7:0] data_out,
  output logic       busy,
  output logic       err,
  output logic       rx_ack,
  output logic       tx_ack,
  output logic       irq,
  output logic       scl,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic       rst_i_n;
  logic       tick;
  logic       run;
  logic       done;
  logic       go;
  logic       accept;
  logic       legal;
  logic       ack_seen;
  logic [7:0] rx_byte;
  twc_op_e    dec_op;

  logic       busy_q, busy_d;
  logic       err_q, err_d;
  logic       rxack_q, rxack_d;
  logic       txack_q, txack_d;
  logic       irq_q, irq_d;
  logic [3:0] cmd_q, cmd_d;
  logic [7:0] data_q, data_d;
  twc_op_e    cur_q, cur_d;

  twc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  twc_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .run(run), .tick(tick)
  );

  twc_decode u_dec (.code(cmd_in), .op(dec_op), .legal(legal));

  assign accept = cmd_wr && !busy_q;
  assign go     = accept && legal && (dec_op != OP_NONE);

  twc_engine u_eng (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .go(go), .op(dec_op),
    .tx_byte(data_q), .sda_in(sda_in), .run(run), .done(done),
    .rx_byte(rx_byte), .ack_seen(ack_seen), .scl(scl), .sda_oe(sda_oe)
  );

  always_comb begin
    busy_d  = busy_q;
    err_d   = err_q;
    rxack_d = rxack_q;
    txack_d = txack_q;
    cmd_d   = cmd_q;
    data_d  = data_q;
    cur_d   = cur_q;
    if (data_wr && !busy_q) data_d = data_in;
    if (accept) begin
      cmd_d   = cmd_in;
      err_d   = !legal;
      rxack_d = 1'b0;
      txack_d = 1'b0;
      busy_d  = go;
      cur_d   = dec_op;
    end
    if (done) begin
      busy_d = 1'b0;
      if (cur_q == OP_TX) rxack_d = ack_seen;
      if ((cur_q == OP_RX_ACK) || (cur_q == OP_RX_NACK)) begin
        data_d  = rx_byte;
        txack_d = (cur_q == OP_RX_ACK);
      end
    end
    irq_d = busy_q && !busy_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      rxack_q <= 1'b0;
      txack_q <= 1'b0;
      irq_q   <= 1'b0;
      cmd_q   <= CODE_NOP;
      data_q  <= '0;
      cur_q   <= OP_NONE;
    end else begin
      busy_q  <= busy_d;
      err_q   <= err_d;
      rxack_q <= rxack_d;
      txack_q <= txack_d;
      irq_q   <= irq_d;
      cmd_q   <= cmd_d;
      data_q  <= data_d;
      cur_q   <= cur_d;
    end
  end

  assign cmd_out  = cmd_q;
  assign data_out = data_q;
  assign busy     = busy_q;
  assign err      = err_q;
  assign rx_ack   = rxack_q;
  assign tx_ack   = txack_q;
  assign irq      = irq_q;
endmodule

// File: rtl/twc_eeprom_master_chk.sv
module twc_eeprom_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [3:0] cmd_in,
  input logic [3:0] cmd_out,
  input logic       busy,
  input logic       err,
  input logic       rx_ack,
  input logic       tx_ack,
  input logic       irq,
  input logic       scl,
  input logic       sda_oe
);
  logic bad_code;
  assign bad_code = !(cmd_in == 4'b0000 || cmd_in == 4'b0010 || cmd_in == 4'b0011 ||
                      cmd_in == 4'b0101 || cmd_in == 4'b0110 || cmd_in == 4'b1001);

  // R10
  irq_on_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  // R10
  irq_only_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));

  // R8
  illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && bad_code) |=> (err && !busy));

  // R7
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || ($stable(scl) && $stable(sda_oe))));

  // R4
  data_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl) && scl && (sda_oe != $past(sda_oe))) |->
      (cmd_out == 4'b1001 || cmd_out == 4'b0101));

  // R6
  ack_flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ack && tx_ack));

  // R11
  cmd_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_out));
endmodule

bind twc_eeprom_master twc_eeprom_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in), .cmd_out(cmd_out),
  .busy(busy), .err(err), .rx_ack(rx_ack), .tx_ack(tx_ack), .irq(irq),
  .scl(scl), .sda_oe(sda_oe)
);

// File: tb/twc_eeprom_master_test.sv
module twc_eeprom_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 3;

  typedef struct {
    int         kind;   // 1 start, 2 stop, 3 byte
    logic [7:0] b;
    logic       ack;    // line level at ninth clock
    string      tag;
  } item_t;

  logic clk, rst_n, cmd_wr, data_wr, sda_in;
  logic [3:0] cmd_in, cmd_out;
  logic [7:0] data_in, data_out;
  logic busy, err, rx_ack, tx_ack, irq, scl, sda_oe;

  int nchk = 0;
  int nfail = 0;
  item_t exp_q[$];

  // slave model
  int slv_mode = 0;       // 0 idle, 1 listen, 2 send
  int slv_k = 0;
  logic [7:0] slv_byte = 8'h00;
  logic slv_ack = 1'b0;
  logic slv_low = 1'b0;
  wire sda_line = !(sda_oe === 1'b1 || slv_low);
  assign sda_in = sda_line;

  twc_eeprom_master #(.QTR_CYCLES(QTR)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
    .data_wr(data_wr), .data_in(data_in), .cmd_out(cmd_out), .data_out(data_out),
    .busy(busy), .err(err), .rx_ack(rx_ack), .tx_ack(tx_ack), .irq(irq),
    .scl(scl), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = !clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic sb_event(input int kind, input logic [7:0] b, input logic a);
    item_t e;
    if (exp_q.size() == 0) begin
      check(0, "R7", "unexpected bus event kind", kind, 0);
    end else begin
      e = exp_q.pop_front();
      check(kind == e.kind, e.tag, "bus event kind", kind, e.kind);
      if (kind == 3 && e.kind == 3) begin
        check(b == e.b, e.tag, "byte on bus", b, e.b);
        check(a == e.ack, e.tag, "ack level", a, e.ack);
      end
    end
  endtask

  // bus monitor
  int mon_cnt = 0;
  logic [7:0] mon_sh = 8'h00;
  always @(negedge sda_line) if (rst_n && scl === 1'b1) begin
    mon_cnt = 0; sb_event(1, 8'h00, 1'b0);
  end
  always @(posedge sda_line) if (rst_n && scl === 1'b1) begin
    mon_cnt = 0; sb_event(2, 8'h00, 1'b0);
  end
  always @(posedge scl) if (rst_n) begin
    if (mon_cnt < 8) begin
      mon_sh = {mon_sh[6:0], sda_line};
      mon_cnt++;
    end else begin
      sb_event(3, mon_sh, sda_line);
      mon_cnt = 0;
    end
  end

  // slave responder: changes the line only on falling scl
  always @(negedge scl) if (rst_n && slv_mode != 0) begin
    slv_k++;
    if (slv_mode == 2) slv_low = (slv_k < 8) ? !slv_byte[7 - slv_k] : 1'b0;
    else               slv_low = (slv_k == 8) && slv_ack;
    if (slv_k >= 9) begin
      slv_mode = 0;
      slv_low = 1'b0;
    end
  end

  // scl high length
  int hcnt = 0;
  int last_high = 0;
  always @(posedge clk) begin
    if (scl === 1'b1) hcnt++;
    else begin
      if (hcnt != 0) last_high = hcnt;
      hcnt = 0;
    end
  end

  task automatic push(input int kind, input logic [7:0] b, input logic a, input string tag);
    item_t e;
    e.kind = kind; e.b = b; e.ack = a; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic arm_slave(input int mode, input logic [7:0] b, input logic a);
    slv_k = 0; slv_byte = b; slv_ack = a; slv_mode = mode;
    slv_low = (mode == 2) ? !b[7] : 1'b0;
  endtask

  task automatic write_data(input logic [7:0] b);
    @(negedge clk); data_in = b; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic run_cmd(input logic [3:0] c, input bit active, input bit poke);
    int n;
    @(negedge clk); cmd_in = c; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    if (active) begin
      check(busy == 1'b1, "R10", "busy after write", busy, 1);
      n = 0;
      while (busy && n < 5000) begin
        if (poke && n == 2) begin
          cmd_in = 4'b1001; cmd_wr = 1'b1; data_in = 8'h00; data_wr = 1'b1;
        end else begin
          cmd_wr = 1'b0; data_wr = 1'b0;
        end
        @(negedge clk);
        n++;
      end
      cmd_wr = 1'b0; data_wr = 1'b0;
      check(irq == 1'b1, "R10", "irq when busy falls", irq, 1);
      @(negedge clk);
      check(irq == 1'b0, "R10", "irq one cycle", irq, 0);
    end else begin
      check(busy == 1'b0, "R7", "no busy", busy, 0);
      check(irq == 1'b0, "R8", "no irq", irq, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R10", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_in = 4'h0; data_wr = 1'b0; data_in = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(cmd_out == 4'b0000, "R1", "cmd_out", cmd_out, 0);
    check(data_out == 8'h00, "R1", "data_out", data_out, 0);
    check({busy, err, rx_ack, tx_ack, irq} == 5'b0, "R1", "status", {busy, err, rx_ack, tx_ack, irq}, 0);
    check(scl == 1'b1 && sda_oe == 1'b0, "R1", "pins {scl,oe}", {scl, sda_oe}, 2);

    // R2 start
    push(1, 8'h00, 1'b0, "R2");
    run_cmd(4'b1001, 1'b1, 1'b0);
    check(scl == 1'b0, "R2", "scl low after start", scl, 0);

    // R4 send with ack, R12 timing
    write_data(8'hA5);
    arm_slave(1, 8'h00, 1'b1);
    push(3, 8'hA5, 1'b0, "R4");
    run_cmd(4'b0011, 1'b1, 1'b0);
    check(rx_ack == 1'b1, "R4", "rx_ack after acked send", rx_ack, 1);
    check(last_high == 2 * QTR, "R12", "scl high cycles", last_high, 2 * QTR);

    // R4 send without ack; R11 writes during busy ignored
    write_data(8'h3C);
    arm_slave(1, 8'h00, 1'b0);
    push(3, 8'h3C, 1'b1, "R4");
    run_cmd(4'b0011, 1'b1, 1'b1);
    check(rx_ack == 1'b0, "R4", "rx_ack after nacked send", rx_ack, 0);
    check(cmd_out == 4'b0011, "R11", "cmd held while busy", cmd_out, 3);
    check(data_out == 8'h3C, "R11", "data held while busy", data_out, 8'h3C);

    // R5 receive with ack
    arm_slave(2, 8'h5A, 1'b0);
    push(3, 8'h5A, 1'b0, "R5");
    run_cmd(4'b0010, 1'b1, 1'b0);
    check(data_out == 8'h5A, "R5", "received byte", data_out, 8'h5A);
    check(tx_ack == 1'b1, "R5", "tx_ack set", tx_ack, 1);

    // R7 no-op clears status (R9)
    run_cmd(4'b0000, 1'b0, 1'b0);
    check(tx_ack == 1'b0 && err == 1'b0, "R9", "status cleared by nop", {tx_ack, err}, 0);
    check(cmd_out == 4'b0000, "R7", "nop latched", cmd_out, 0);

    // R8 illegal codes
    run_cmd(4'b1111, 1'b0, 1'b0);
    check(err == 1'b1, "R8", "err on 1111", err, 1);
    run_cmd(4'b0001, 1'b0, 1'b0);
    check(err == 1'b1, "R8", "err on 0001", err, 1);
    repeat (3 * QTR) @(negedge clk);
    check(scl == 1'b0 && busy == 1'b0, "R8", "bus quiet after illegal", {scl, busy}, 0);

    // R6 receive last, clears err (R9)
    arm_slave(2, 8'h81, 1'b0);
    push(3, 8'h81, 1'b1, "R6");
    run_cmd(4'b0110, 1'b1, 1'b0);
    check(err == 1'b0, "R9", "err cleared by next command", err, 0);
    check(data_out == 8'h81, "R6", "last byte", data_out, 8'h81);
    check(tx_ack == 1'b0, "R6", "no tx_ack", tx_ack, 0);

    // R3 stop
    push(2, 8'h00, 1'b0, "R3");
    run_cmd(4'b0101, 1'b1, 1'b0);
    check(scl == 1'b1 && sda_line == 1'b1, "R3", "bus idle after stop", {scl, sda_line}, 3);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2", "all expected bus events seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule